// File: doc/BRIEF.md
# Capture/Reload Timer with Direction Control

A 16-bit timer and event counter for a microcontroller peripheral bus. It has one count register, one 16-bit register that holds either a reload value or a captured count, and a single external trigger pin. Depending on the mode, that pin triggers a capture, forces a reload, or sets the count direction. The block counts in one of two ways. In timer mode it counts a machine-cycle enable that fires once every twelve clocks. In counter mode it counts falling edges on an external count pin, which is sampled once per machine cycle.

Software reaches the block through a simple register port. A write strobe carries a select and a data word. A separate read select drives a combinational read bus. The block raises two sticky flags, overflow and external. Their OR forms an interrupt request, except in up/down mode: there the external flag acts as a seventeenth count bit and is kept out of the interrupt. Both pins are assumed to be already synchronous to the clock.

Top module: `cr_timer16`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. This covers the control word, count, reload/capture, both flags and both pin samples. The interrupt request is low.
- R2: In timer mode (count-source bit 0), with run set, the count rises by one on each machine-cycle enable (every 12 clocks). With run clear, the count holds.
- R3: In counter mode (count-source bit 1), the count pin is sampled on each machine-cycle enable. The count rises by one in the clock after a sample that reads low when the previous sample read high. A pin held at each level for at least 24 clocks is counted once per falling edge.
- R4: In capture mode with trigger-enable set, a trigger-pin falling edge has two effects one clock later. The count value from before the edge is copied into the reload/capture register, and the external flag is set. Counting continues.
- R5: In capture mode, an increment from FFFFh wraps the count to 0000h and sets the overflow flag. No reload takes place.
- R6: In reload mode with down-count disabled, an increment from FFFFh loads the count from the reload register and sets the overflow flag. With trigger-enable set, a trigger falling edge also loads the reload value and sets the external flag.
- R7: In reload mode with down-count enabled, the sampled trigger level sets the direction: high counts up, low counts down. When a down step starts from a count equal to the reload value, the count loads FFFFh and the overflow flag is set. An up step from FFFFh reloads as in R6.
- R8: In up/down mode, the external flag toggles on every overflow and underflow. Trigger edges do not set it, and it does not drive the interrupt request.
- R9: The overflow flag and the external flag are sticky and change only through a control-word write or a hardware event. The interrupt request is the OR of the overflow flag and the external flag (the latter outside up/down mode). A hardware set or toggle in the same cycle as a software write wins.
- R10: With trigger-enable clear, trigger-pin edges cause no capture, no reload and no flag change.
- R11: A hardware reload (overflow, underflow or trigger) wins over a software write to the count in the same cycle. A software write wins over a plain increment.
- R12: Register select 0 is the control word. Its bits are: 0 run, 1 count source, 2 capture mode, 3 trigger enable, 4 down-count enable, 6 overflow flag, 7 external flag. All other bits read 0. Select 1 is the count, select 2 is reload/capture, and select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_pin | input | 1 | External event input counted in counter mode |
| trig_pin | input | 1 | Capture/reload trigger or count direction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select for writes |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Register select for reads |
| rd_data | output | 16 | Read data, combinational from rd_sel |
| ovf_flag | output | 1 | Sticky overflow/underflow flag |
| ext_flag | output | 1 | Sticky external flag (17th bit in up/down mode) |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and all count, capture and flag effects show on the outputs one clock after the edge that applies them. A pin edge needs a machine-cycle enable to sample it, and then one more clock before the count, capture register or flag moves. The latency from a pin edge is therefore between 2 and 13 clocks, depending on the prescaler phase. The bench's behavioural model advances at each rising edge and is compared with every output a quarter period later, so each result is judged in the exact cycle it is due. The same-cycle collision cases are lined up by waiting until the model shows a pending trigger event, then issuing the write in that very cycle.

// File: rtl/crt_pkg.sv
// Shared definitions for the capture/reload timer: register selects and
// control-word bit positions. Assumes a data width of at least 8 bits.
package crt_pkg;
    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_RELOAD = 2'd2,
        SEL_NONE   = 2'd3
    } crt_sel_e;

    localparam int BIT_RUN   = 0;
    localparam int BIT_SRC   = 1;
    localparam int BIT_CAPT  = 2;
    localparam int BIT_TRGEN = 3;
    localparam int BIT_UPDN  = 4;
    localparam int BIT_OVF   = 6;
    localparam int BIT_EXT   = 7;
endpackage

// File: rtl/crt_prescale.sv
// Machine-cycle enable generator: emits a one-clock pulse every DIV clocks.
// Assumes DIV >= 2. Synchronous active-low reset starts the phase at zero.
module crt_prescale #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] phase_q;

    // Phase counter wraps after DIV states.
    always_ff @(posedge clk) begin
        if (!rst_n)            phase_q <= '0;
        else if (phase_q == LAST) phase_q <= '0;
        else                   phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == LAST);

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/crt_edge_det.sv
// Sample-twice falling-edge detector. The pin is sampled on each tick; a
// high sample followed by a low one gives a one-clock pulse in the clock
// after that tick. The pin is assumed synchronous to clk.
module crt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin,
    output logic level,
    output logic fall
);
    logic samp_q;
    logic fall_q;

    // Keep the latest sample and flag a high-to-low pair of samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            samp_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            fall_q <= tick & samp_q & ~pin;
            if (tick) samp_q <= pin;
        end
    end

    assign level = samp_q;
    assign fall  = fall_q;

    // R3
    fall_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fall |-> $past(tick));
endmodule

// File: rtl/cr_timer16.sv
// Capture/reload timer with trigger-controlled direction. Holds the control
// word, count, reload/capture register and two sticky flags. Counts either
// machine-cycle ticks or count-pin falling edges. Both pins are assumed
// synchronous to clk. CNT_W must be at least 8 to hold the control word.
module cr_timer16 #(
    parameter int CNT_W  = 16,
    parameter int MC_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_pin,
    input  logic             trig_pin,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             ovf_flag,
    output logic             ext_flag,
    output logic             irq
);
    import crt_pkg::*;

    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    logic tick, cnt_fall, cnt_lvl, trg_fall, trg_lvl;

    crt_prescale #(.DIV(MC_DIV)) pre_i (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    crt_edge_det cnt_det_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin),
        .level(cnt_lvl), .fall(cnt_fall));

    crt_edge_det trg_det_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pin(trig_pin),
        .level(trg_lvl), .fall(trg_fall));

    logic ctl_run, ctl_src, ctl_capt, ctl_trgen, ctl_updn;
    logic ovf_q, ext_q;
    logic [CNT_W-1:0] count_q, rel_q;

    logic wr_ctrl, wr_cnt, wr_rel;
    logic updown, dir_up, inc_evt, trg_evt, ovf_evt, unf_evt, cap_evt, hw_load;
    logic [CNT_W-1:0] load_val;

    assign wr_ctrl = wr_en && (crt_sel_e'(wr_sel) == SEL_CTRL);
    assign wr_cnt  = wr_en && (crt_sel_e'(wr_sel) == SEL_COUNT);
    assign wr_rel  = wr_en && (crt_sel_e'(wr_sel) == SEL_RELOAD);

    // Event decode: direction, increments, wraps and trigger actions.
    assign updown   = ctl_updn & ~ctl_capt;
    assign dir_up   = ~updown | trg_lvl;
    assign inc_evt  = ctl_run & (ctl_src ? cnt_fall : tick);
    assign trg_evt  = ctl_trgen & trg_fall & ~updown;
    assign ovf_evt  = inc_evt & dir_up & (count_q == ALL_ONES);
    assign unf_evt  = inc_evt & ~dir_up & (count_q == rel_q);
    assign cap_evt  = ctl_capt & trg_evt;
    assign hw_load  = ~ctl_capt & (ovf_evt | unf_evt | trg_evt);
    assign load_val = unf_evt ? ALL_ONES : rel_q;

    // Control bits are loaded only by a control-word write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_run <= 1'b0; ctl_src <= 1'b0; ctl_capt <= 1'b0;
            ctl_trgen <= 1'b0; ctl_updn <= 1'b0;
        end else if (wr_ctrl) begin
            ctl_run   <= wr_data[BIT_RUN];
            ctl_src   <= wr_data[BIT_SRC];
            ctl_capt  <= wr_data[BIT_CAPT];
            ctl_trgen <= wr_data[BIT_TRGEN];
            ctl_updn  <= wr_data[BIT_UPDN];
        end
    end

    // Count: hardware reload beats a software write, which beats a step.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (hw_load) count_q <= load_val;
        else if (wr_cnt)  count_q <= wr_data;
        else if (inc_evt) count_q <= dir_up ? count_q + 1'b1 : count_q - 1'b1;
    end

    // Reload/capture register: capture beats a software write.
    always_ff @(posedge clk) begin
        if (!rst_n)       rel_q <= '0;
        else if (cap_evt) rel_q <= count_q;
        else if (wr_rel)  rel_q <= wr_data;
    end

    // Sticky flags: hardware events take priority over software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            ext_q <= 1'b0;
        end else begin
            if (ovf_evt | unf_evt) ovf_q <= 1'b1;
            else if (wr_ctrl)      ovf_q <= wr_data[BIT_OVF];
            if (updown & (ovf_evt | unf_evt)) ext_q <= ~ext_q;
            else if (trg_evt)                 ext_q <= 1'b1;
            else if (wr_ctrl)                 ext_q <= wr_data[BIT_EXT];
        end
    end

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (crt_sel_e'(rd_sel))
            SEL_CTRL: begin
                rd_data[BIT_RUN]   = ctl_run;
                rd_data[BIT_SRC]   = ctl_src;
                rd_data[BIT_CAPT]  = ctl_capt;
                rd_data[BIT_TRGEN] = ctl_trgen;
                rd_data[BIT_UPDN]  = ctl_updn;
                rd_data[BIT_OVF]   = ovf_q;
                rd_data[BIT_EXT]   = ext_q;
            end
            SEL_COUNT:  rd_data = count_q;
            SEL_RELOAD: rd_data = rel_q;
            default:    rd_data = '0;
        endcase
    end

    assign ovf_flag = ovf_q;
    assign ext_flag = ext_q;
    assign irq      = ovf_q | (ext_q & ~updown);

    // R4
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |=> (rel_q == $past(count_q)) && ext_q);
    // R5
    capture_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_capt && ovf_evt && !wr_cnt) |=> (count_q == '0) && ovf_q);
    // R7
    underflow_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_evt |=> (count_q == ALL_ONES) && ovf_q);
    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_q) |-> $past(wr_ctrl));
    // R2
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_run && !hw_load && !wr_cnt) |=> $stable(count_q));
endmodule

// File: tb/cr_timer16_tb.sv
// Bench for cr_timer16: behavioural reference model stepped on each rising
// edge, compared with all outputs a quarter period later, plus directed checks.
module cr_timer16_tb_top;
    localparam int CLK_P = 10;
    localparam int DIV   = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cnt_pin = 1'b1, trig_pin = 1'b1;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic [1:0] rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic ovf_flag, ext_flag, irq;

    int n_chk = 0, n_err = 0;
    bit rot_en = 1'b1;

    cr_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
        .rd_data(rd_data), .ovf_flag(ovf_flag), .ext_flag(ext_flag), .irq(irq));

    always #(CLK_P/2) clk = ~clk;

    // Reference model state
    int m_pc;
    bit m_run, m_src, m_cp, m_te, m_dn, m_of, m_ef;
    bit m_clev, m_cfall, m_tlev, m_tfall;
    logic [15:0] m_cnt, m_rel;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(bit run, bit src, bit cp, bit te, bit dn, bit of, bit ef);
        return {8'h00, ef, of, 1'b0, dn, te, cp, src, run};
    endfunction

    function automatic logic [15:0] m_read(logic [1:0] s);
        case (s)
            2'd0: return mk(m_run, m_src, m_cp, m_te, m_dn, m_of, m_ef);
            2'd1: return m_cnt;
            2'd2: return m_rel;
            default: return 16'h0;
        endcase
    endfunction

    // Model step at the rising edge, then compare outputs a quarter period later.
    always @(posedge clk) begin
        bit tk, ud, up, inc, trg, ov, un, wc, wn, wl;
        logic [15:0] n_cnt;
        if (!rst_n) begin
            m_pc = 0; m_run = 0; m_src = 0; m_cp = 0; m_te = 0; m_dn = 0;
            m_of = 0; m_ef = 0; m_clev = 0; m_cfall = 0; m_tlev = 0; m_tfall = 0;
            m_cnt = 0; m_rel = 0;
        end else begin
            tk  = (m_pc == DIV - 1);
            ud  = m_dn && !m_cp;
            up  = !ud || m_tlev;
            inc = m_run && (m_src ? m_cfall : tk);
            trg = m_te && m_tfall && !ud;
            ov  = inc && up && (m_cnt == 16'hFFFF);
            un  = inc && !up && (m_cnt == m_rel);
            wc  = wr_en && wr_sel == 2'd0;
            wn  = wr_en && wr_sel == 2'd1;
            wl  = wr_en && wr_sel == 2'd2;
            n_cnt = m_cnt;
            if (!m_cp && un)                 n_cnt = 16'hFFFF;
            else if (!m_cp && (ov || trg))   n_cnt = m_rel;
            else if (wn)                     n_cnt = wr_data;
            else if (inc)                    n_cnt = up ? m_cnt + 16'd1 : m_cnt - 16'd1;
            if (m_cp && trg)  m_rel = m_cnt;
            else if (wl)      m_rel = wr_data;
            m_cnt = n_cnt;
            if (ov || un)     m_of = 1;
            else if (wc)      m_of = wr_data[6];
            if (ud && (ov || un)) m_ef = !m_ef;
            else if (trg)     m_ef = 1;
            else if (wc)      m_ef = wr_data[7];
            if (wc) begin
                m_run = wr_data[0]; m_src = wr_data[1]; m_cp = wr_data[2];
                m_te = wr_data[3]; m_dn = wr_data[4];
            end
            m_cfall = tk && m_clev && !cnt_pin;
            m_tfall = tk && m_tlev && !trig_pin;
            if (tk) begin m_clev = cnt_pin; m_tlev = trig_pin; end
            m_pc = tk ? 0 : m_pc + 1;
        end
        #(CLK_P/4);
        if (rst_n) begin
            case (rd_sel)
                2'd0: chk("R12 control word read", rd_data, m_read(2'd0));
                2'd1: chk("R2 count read", rd_data, m_read(2'd1));
                2'd2: chk("R4 reload/capture read", rd_data, m_read(2'd2));
                default: chk("R12 unused select read", rd_data, 16'h0);
            endcase
            chk("R9 overflow flag", {15'h0, ovf_flag}, {15'h0, m_of});
            chk("R8 external flag", {15'h0, ext_flag}, {15'h0, m_ef});
            chk("R9 interrupt request", {15'h0, irq},
                {15'h0, m_of || (m_ef && !(m_dn && !m_cp))});
        end
    end

    // Rotate the read select so every register is compared continuously.
    always @(negedge clk) if (rot_en) rd_sel <= rd_sel + 2'd1;

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] v);
        rot_en = 1'b0;
        @(negedge clk);
        rd_sel = s;
        #1 v = rd_data;
        rot_en = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Waits until a trigger event is pending for the next edge, then writes.
    task automatic wr_on_trigger(input logic [1:0] s, input logic [15:0] d);
        trig_pin = 1'b0;
        do @(negedge clk); while (!m_tfall);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog expired: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] v, hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values
        rd(2'd0, v); chk("R1 control after reset", v, 16'h0000);
        rd(2'd1, v); chk("R1 count after reset", v, 16'h0000);
        rd(2'd2, v); chk("R1 reload after reset", v, 16'h0000);
        chk("R1 irq after reset", {15'h0, irq}, 16'h0000);
        idle(30);

        // R2 / R6: timer mode, reload on overflow
        wr(2'd2, 16'hFFF8);
        wr(2'd1, 16'hFFF0);
        wr(2'd0, mk(1,0,0,0,0,0,0));
        idle(DIV * 18);
        chk("R6 overflow flag after wrap", {15'h0, ovf_flag}, 16'h0001);
        rd(2'd1, v); chk("R6 count reloaded above reload value", {15'h0, v >= 16'hFFF8}, 16'h0001);
        wr(2'd0, mk(0,0,0,0,0,0,0));
        chk("R9 overflow flag cleared by write", {15'h0, ovf_flag}, 16'h0000);
        rd(2'd1, hold); idle(100);
        rd(2'd1, v); chk("R2 count holds while stopped", v, hold);

        // R6: trigger-forced reload
        wr(2'd2, 16'h0100);
        wr(2'd0, mk(1,0,0,1,0,0,0));
        trig_pin = 1'b0; idle(30); trig_pin = 1'b1; idle(2);
        chk("R6 external flag after trigger", {15'h0, ext_flag}, 16'h0001);
        chk("R9 irq from external flag", {15'h0, irq}, 16'h0001);
        rd(2'd1, v); chk("R6 count near reload value", {15'h0, v >= 16'h0100 && v < 16'h0104}, 16'h0001);
        idle(30);

        // R4 / R5: capture mode, wrap without reload
        wr(2'd0, mk(1,0,1,1,0,0,0));
        wr(2'd1, 16'hFFFD);
        idle(DIV * 2);
        trig_pin = 1'b0; idle(30); trig_pin = 1'b1;
        rd(2'd2, v); chk("R4 captured count", v, m_rel);
        chk("R4 external flag set by capture", {15'h0, ext_flag}, 16'h0001);
        idle(DIV * 4);
        chk("R5 overflow flag in capture mode", {15'h0, ovf_flag}, 16'h0001);
        rd(2'd1, v); chk("R5 count wrapped without reload", {15'h0, v < 16'h0010}, 16'h0001);

        // R10: trigger ignored with trigger-enable clear
        wr(2'd0, mk(1,0,1,0,0,0,0));
        rd(2'd2, hold);
        trig_pin = 1'b0; idle(30); trig_pin = 1'b1; idle(30);
        rd(2'd2, v); chk("R10 capture register untouched", v, hold);
        chk("R10 external flag untouched", {15'h0, ext_flag}, 16'h0000);

        // R3: counter mode, five pin falls
        wr(2'd0, mk(1,1,0,0,0,0,0));
        wr(2'd1, 16'h0000);
        for (int i = 0; i < 5; i++) begin
            cnt_pin = 1'b0; idle(30); cnt_pin = 1'b1; idle(30);
        end
        rd(2'd1, v); chk("R3 count of pin falls", v, 16'h0005);

        // R7 / R8: down count to underflow, then up to overflow
        wr(2'd0, mk(0,0,0,0,1,0,0));
        wr(2'd2, 16'h0010);
        wr(2'd1, 16'h0013);
        trig_pin = 1'b0; idle(30);
        wr(2'd0, mk(1,0,0,0,1,0,0));
        idle(DIV * 6);
        chk("R7 overflow flag on underflow", {15'h0, ovf_flag}, 16'h0001);
        chk("R8 external flag toggled on underflow", {15'h0, ext_flag}, 16'h0001);
        rd(2'd1, v); chk("R7 count loaded all-ones then down", {15'h0, v >= 16'hFFF0}, 16'h0001);
        wr(2'd0, mk(1,0,0,0,1,0,1));
        chk("R8 external flag alone raises no irq", {15'h0, irq}, 16'h0000);
        trig_pin = 1'b1;
        idle(DIV * 20);
        chk("R7 overflow flag on up wrap", {15'h0, ovf_flag}, 16'h0001);
        chk("R8 external flag toggled back", {15'h0, ext_flag}, 16'h0000);
        idle(30);

        // R11: hardware reload wins over a same-cycle count write
        wr(2'd0, mk(1,0,0,1,0,0,0));
        wr(2'd2, 16'h0040);
        idle(30);
        wr_on_trigger(2'd1, 16'h1234);
        rd(2'd1, v); chk("R11 reload beats count write", v, 16'h0040);
        trig_pin = 1'b1; idle(30);

        // R9: flag set wins over a same-cycle clearing write
        wr(2'd0, mk(1,0,0,1,0,0,0));
        idle(30);
        wr_on_trigger(2'd0, mk(1,0,0,1,0,0,0));
        chk("R9 set wins over clear", {15'h0, ext_flag}, 16'h0001);
        trig_pin = 1'b1; idle(30);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule